// File: doc/BRIEF.md
# Single-Accumulator Processor Core

A small sequential processor built around one 16-bit accumulator. It fetches 16-bit instruction words from a synchronous memory and runs them one at a time. Each word holds a 4-bit operation code and a 12-bit direct operand address. The core supports six operations:

- loading the accumulator from memory;
- adding a memory word to the accumulator;
- subtracting a memory word from the accumulator;
- storing the accumulator to memory;
- a conditional jump taken when the accumulator is nonzero;
- a stop that freezes the core.

Every instruction spends one cycle in a fetch state and one cycle in an execute state, with exactly one memory access in each. The memory has one cycle of read latency. The fetch of the next instruction therefore overlaps the return of the previous instruction's operand, and the accumulator takes its new value at the end of that fetch cycle.

The memory port carries a 12-bit byte address. The 16-bit word that belongs to an address sits at that address with bit 0 cleared. Instructions sit two bytes apart. A debug view of the accumulator and program counter, plus a halted flag, lets a test harness or a surrounding system watch progress.

Top module: `acc_core`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, pc_o and acc_o read 0, halted_o is 0 and mem_we_o is 0.
- R2: An instruction word holds its operation in bits [15:12] and its operand address in bits [11:0]. The operation codes are: 0 load, 1 store, 2 add, 3 subtract, 6 jump-if-nonzero, 7 stop.
- R3: Each instruction takes exactly two cycles. In the fetch cycle, mem_addr_o equals pc_o. In the execute cycle, mem_addr_o equals the operand address field. mem_we_o is never high in two consecutive cycles.
- R4: Load, add and subtract set acc_o to mem, acc+mem and acc-mem respectively, all modulo 2^16. The new value appears after the fetch cycle that follows the instruction's execute cycle.
- R5: A store drives the accumulator onto mem_wdata_o with mem_we_o high for one cycle, at the operand address. The accumulator is unchanged by it.
- R6: Every instruction that does not jump advances pc_o by 2, wrapping modulo 2^12 (0xFFE is followed by 0x000).
- R7: Jump-if-nonzero loads pc_o with the operand address field when acc_o is nonzero. When acc_o is zero, it advances pc_o by 2.
- R8: After a stop, halted_o is high and pc_o (left at the stop's address), acc_o and the memory hold, with no writes, until reset.
- R9: Operation codes 4, 5 and 8 to 15 act as no-operations: pc_o advances by 2, the accumulator is unchanged, and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 12 | Memory byte address (instruction or operand) |
| mem_wdata_o | output | 16 | Store data |
| mem_we_o | output | 1 | Write enable for the store |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the address |
| halted_o | output | 1 | High once a stop has executed |
| acc_o | output | 16 | Debug view of the accumulator |
| pc_o | output | 12 | Debug view of the program counter |

## Verification
The assertions assume that mem_rdata_i always returns the word addressed in the previous cycle. They also assume that reset is the only way out of the halted state. The jump check allows an arbitrary target, but only when the accumulator was nonzero; otherwise the program counter must step by two or hold. The bench drives the core only through a memory model with one cycle of read latency. That model returns the word at the previous cycle's address with bit 0 dropped. The bench reasserts reset before loading each program.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam logic [3:0] OPC_LOAD  = 4'd0;
  localparam logic [3:0] OPC_STORE = 4'd1;
  localparam logic [3:0] OPC_ADD   = 4'd2;
  localparam logic [3:0] OPC_SUB   = 4'd3;
  localparam logic [3:0] OPC_JNZ   = 4'd6;
  localparam logic [3:0] OPC_STOP  = 4'd7;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} core_state_e;
  typedef enum logic [1:0] {PEND_NONE, PEND_LOAD, PEND_ADD, PEND_SUB} pend_e;
endpackage

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
  import acc_core_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic            acc_zero_i,
  output core_state_e     state_o,
  output pend_e           pend_o,
  output logic            adv_pc_o,
  output logic            jump_o,
  output logic            store_o
);
  core_state_e state_q, state_d;
  pend_e       pend_q, pend_d;
  logic        in_exec;

  assign in_exec = (state_q == ST_EXEC);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH: state_d = ST_EXEC;
      ST_EXEC:  state_d = (op_i == OPC_STOP) ? ST_HALT : ST_FETCH;
      default:  state_d = ST_HALT;
    endcase
  end

  // operand arrives during the next fetch; remember what to do with it
  always_comb begin
    pend_d = PEND_NONE;
    if (in_exec) begin
      unique case (op_i)
        OPC_LOAD: pend_d = PEND_LOAD;
        OPC_ADD:  pend_d = PEND_ADD;
        OPC_SUB:  pend_d = PEND_SUB;
        default:  pend_d = PEND_NONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pend_q  <= PEND_NONE;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign state_o  = state_q;
  assign pend_o   = pend_q;
  assign adv_pc_o = in_exec && (op_i != OPC_STOP);
  assign jump_o   = in_exec && (op_i == OPC_JNZ) && !acc_zero_i;
  assign store_o  = in_exec && (op_i == OPC_STORE);
endmodule

// File: rtl/acc_core_datapath.sv
module acc_core_datapath
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              apply_i,
  input  pend_e             pend_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] acc_o
);
  logic [DATA_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (apply_i) begin
      unique case (pend_i)
        PEND_LOAD: acc_d = operand_i;
        PEND_ADD:  acc_d = acc_q + operand_i;
        PEND_SUB:  acc_d = acc_q - operand_i;
        default:   acc_d = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/acc_core_pc.sv
module acc_core_pc #(
  parameter int ADDR_W = 12,
  parameter int STRIDE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              jump_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] Step = ADDR_W'(STRIDE);

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (jump_i) pc_q <= target_i;
    else if (adv_i)  pc_q <= pc_q + Step;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OP_W   = 4,
  parameter int STRIDE = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [OP_W+ADDR_W-1:0] mem_wdata_o,
  output logic                   mem_we_o,
  input  logic [OP_W+ADDR_W-1:0] mem_rdata_i,
  output logic                   halted_o,
  output logic [OP_W+ADDR_W-1:0] acc_o,
  output logic [ADDR_W-1:0]      pc_o
);
  localparam int DATA_W = OP_W + ADDR_W;

  core_state_e       state;
  pend_e             pend;
  logic              adv_pc, jump, store;
  logic [OP_W-1:0]   op_field;
  logic [ADDR_W-1:0] addr_field;
  logic [DATA_W-1:0] acc;
  logic [ADDR_W-1:0] pc;

  // no instruction register: the word is decoded straight off the read port
  assign op_field   = mem_rdata_i[DATA_W-1 -: OP_W];
  assign addr_field = mem_rdata_i[ADDR_W-1:0];

  acc_core_ctrl #(.OP_W(OP_W)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op_field),
    .acc_zero_i (acc == '0),
    .state_o    (state),
    .pend_o     (pend),
    .adv_pc_o   (adv_pc),
    .jump_o     (jump),
    .store_o    (store)
  );

  acc_core_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .apply_i   (state == ST_FETCH),
    .pend_i    (pend),
    .operand_i (mem_rdata_i),
    .acc_o     (acc)
  );

  acc_core_pc #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) pc_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv_pc),
    .jump_i   (jump),
    .target_i (addr_field),
    .pc_o     (pc)
  );

  assign mem_addr_o  = (state == ST_EXEC) ? addr_field : pc;
  assign mem_wdata_o = acc;
  assign mem_we_o    = store;
  assign halted_o    = (state == ST_HALT);
  assign acc_o       = acc;
  assign pc_o        = pc;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_we_i,
  input logic              halted_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [DATA_W-1:0] acc_i
);
  p_halt_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i && $stable(pc_i) && $stable(acc_i));

  p_no_write_halted_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> !mem_we_i);

  p_single_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i);

  p_store_keeps_acc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> $stable(acc_i));

  p_pc_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halted_i |=> (pc_i == $past(pc_i)) || (pc_i == $past(pc_i) + ADDR_W'(2))
                  || ($past(acc_i) != '0));
endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W), .DATA_W(OP_W + ADDR_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mem_we_i (mem_we_o),
  .halted_i (halted_o),
  .pc_i     (pc_o),
  .acc_i    (acc_o)
);

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we, halted;
  logic [15:0] acc;
  logic [11:0] pc;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct packed {logic [11:0] a; logic [15:0] d;} wr_t;
  wr_t exp_q[$];

  logic [15:0] mem [2048];

  always #4 clk = ~clk;

  acc_core dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata),
    .halted_o    (halted),
    .acc_o       (acc),
    .pc_o        (pc)
  );

  // synchronous memory, one cycle read latency, bit 0 of address ignored
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:1]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:1]];
  end

  task automatic check(input string req, input logic ok, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every write is popped against the expected list
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected write", 1'b0, {4'h0, mem_addr, mem_wdata}, 32'h0);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        check("R5 store addr/data", (mem_addr == e.a) && (mem_wdata == e.d),
              {4'h0, mem_addr, mem_wdata}, {4'h0, e.a, e.d});
      end
    end
  end

  task automatic push_wr(input logic [11:0] a, input logic [15:0] d);
    wr_t e;
    e.a = a;
    e.d = d;
    exp_q.push_back(e);
  endtask

  task automatic setw(input logic [11:0] a, input logic [15:0] d);
    mem[a[11:1]] = d;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) mem[i] = 16'h7000;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  // release reset and count rising edges until halted is seen
  task automatic run(output int cycles);
    cycles = 0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 first cycle pc/acc", (pc == 12'h0) && (acc == 16'h0), {pc, acc[3:0]}, 32'h0);
    check("R3 fetch addr is pc", mem_addr == pc, mem_addr, pc);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      cycles++;
      if (halted) break;
    end
  endtask

  initial begin
    #1_000_000;
    check("watchdog", 1'b0, 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [11:0] pc_h;
    logic [15:0] acc_h;

    // reset state R1
    repeat (2) @(negedge clk);
    check("R1 pc in reset", pc == 12'h0, pc, 0);
    check("R1 acc in reset", acc == 16'h0, acc, 0);
    check("R1 halted/we in reset", !halted && !mem_we, {halted, mem_we}, 0);

    // program A: countdown loop 5..0 (R2, R4, R7 taken, R8)
    clear_mem();
    setw(12'h000, 16'h0100);  // load 0x100
    setw(12'h002, 16'h3104);  // sub  0x104
    setw(12'h004, 16'h1100);  // store 0x100
    setw(12'h006, 16'h6000);  // jnz  0x000
    setw(12'h008, 16'h7000);  // stop
    setw(12'h100, 16'd5);
    setw(12'h104, 16'd1);
    for (int k = 4; k >= 0; k--) push_wr(12'h100, 16'(k));
    run(cyc);
    check("R3 two cycles per instruction (21 instr)", cyc == 42, cyc, 42);
    check("R7 falls through to stop, pc", pc == 12'h008, pc, 12'h008);
    check("R4 final acc", acc == 16'h0, acc, 0);
    check("R5 memory updated", mem[12'h100 >> 1] == 16'h0, mem[12'h100 >> 1], 0);
    check("R5 all loop stores seen", exp_q.size() == 0, exp_q.size(), 0);
    pc_h = pc;
    acc_h = acc;
    repeat (10) @(negedge clk);
    check("R8 halted sticky", halted, halted, 1);
    check("R8 pc/acc held", (pc == pc_h) && (acc == acc_h), {pc, acc[3:0]}, {pc_h, acc_h[3:0]});
    check("R8 no write while halted", !mem_we, mem_we, 0);

    // program B: arithmetic wrap, undefined codes, jnz with zero
    enter_reset();
    check("R1 reset from halt", !halted && pc == 0 && acc == 0, {halted, pc}, 0);
    clear_mem();
    setw(12'h000, 16'h0100);  // load 0x7FFF
    setw(12'h002, 16'h2102);  // add 2 -> 0x8001
    setw(12'h004, 16'h4FFE);  // code 4: no-op
    setw(12'h006, 16'h1120);  // store 0x8001
    setw(12'h008, 16'h3104);  // sub 0x8002 -> 0xFFFF
    setw(12'h00A, 16'h1122);  // store 0xFFFF
    setw(12'h00C, 16'hC106);  // code 12: no-op
    setw(12'h00E, 16'h0106);  // load 0
    setw(12'h010, 16'h6000);  // jnz with acc 0: falls through
    setw(12'h012, 16'h5ABC);  // code 5: no-op
    setw(12'h014, 16'h7000);  // stop
    setw(12'h100, 16'h7FFF);
    setw(12'h102, 16'h0002);
    setw(12'h104, 16'h8002);
    setw(12'h106, 16'h0000);
    push_wr(12'h120, 16'h8001);
    push_wr(12'h122, 16'hFFFF);
    run(cyc);
    check("R9 no-ops take two cycles each (11 instr)", cyc == 22, cyc, 22);
    check("R7 zero acc falls through, pc", pc == 12'h014, pc, 12'h014);
    check("R4 add wrap stored", mem[12'h120 >> 1] == 16'h8001, mem[12'h120 >> 1], 16'h8001);
    check("R4 sub wrap stored", mem[12'h122 >> 1] == 16'hFFFF, mem[12'h122 >> 1], 16'hFFFF);
    check("R9 no-op target untouched", mem[12'hFFE >> 1] == 16'h7000, mem[12'hFFE >> 1], 16'h7000);
    check("R5 stores seen", exp_q.size() == 0, exp_q.size(), 0);

    // program C: jump to 0xFFE and wrap of pc to 0x000
    enter_reset();
    clear_mem();
    setw(12'h000, 16'h6008);  // jnz 0x008 (not taken first, taken second)
    setw(12'h002, 16'h0100);  // load 3
    setw(12'h004, 16'h6FFE);  // jnz 0xFFE
    setw(12'hFFE, 16'h1130);  // store 3, then pc wraps
    setw(12'h008, 16'h7000);  // stop
    setw(12'h100, 16'h0003);
    push_wr(12'h130, 16'h0003);
    run(cyc);
    check("R6 wrap path length (6 instr)", cyc == 12, cyc, 12);
    check("R7 taken after wrap, pc at stop", pc == 12'h008, pc, 12'h008);
    check("R4 acc loaded", acc == 16'h0003, acc, 3);
    check("R6 store from 0xFFE seen", exp_q.size() == 0, exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule